// File: doc/BRIEF.md
# I2C Master Stop Condition Sequencer

This block produces the STOP condition on an I2C bus at the end of a byte transfer. Software sets a stop-enable request. The sequencer then holds SCL low and pulls SDA low. It releases SCL and, later, SDA. Every phase waits until the synchronised line level confirms the step before it. A programmable baud-rate counter sets the length of each phase. One period lasts reload+1 system clocks.

Both bus lines are open-drain. The block drives an active-high pull-down enable for each line and reads back the real wire levels through a two-stage synchroniser. A bus monitor watches those levels for START and STOP events and keeps a status bit for each. Software reads these bits to tell whether the bus is busy.

When the sequence completes, the enable bit clears itself and a sticky interrupt flag is raised. A write to the transmit buffer while the sequence runs is refused. The buffer keeps its old value and a sticky collision flag is set.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset the block has these values:
  - both pull-down enables are 0;
  - `stop_busy`, `start_seen`, `stop_seen`, `wr_coll` and `irq_flag` are 0;
  - `tx_buf` is 0x00.
- R2: A `stop_go` pulse while idle sets `stop_busy`. The block first drives SCL low. It drives SDA low only once SCL is sampled low, so SDA falls while the SCL line is low.
- R3: SDA is sampled low, then the counter reloads and runs one period. After that, SCL is released while SDA stays driven low. The time from SDA pull-down to SCL release is between `brg_reload`+1 and `brg_reload`+5 clocks.
- R4: After SCL is released, the counter advances only while SCL is sampled high, so a slave stretching SCL low is honoured. SCL is high for between `brg_reload`+1 and `brg_reload`+4 clocks before SDA is released.
- R5: The sequence completes when SDA is sampled high while SCL is sampled high. At that point `stop_busy` clears, `irq_flag` is set, and both lines are released.
- R6: The monitor uses the synchronised line levels.
  - A STOP is SDA rising while SCL is high. It sets `stop_seen` and clears `start_seen`.
  - A START is SDA falling while SCL is high. It sets `start_seen` and clears `stop_seen`.
  - Bus events driven by another master do not set `irq_flag`.
- R7: A `buf_we` pulse while `stop_busy` is 1 sets `wr_coll` and leaves `tx_buf` unchanged. A `buf_we` pulse while idle loads `buf_wdata` into `tx_buf` and leaves `wr_coll` unchanged.
- R8: `wr_coll` and `irq_flag` stay set until their own clear strobe (`coll_clr`, `irq_clr`) is pulsed. A set event in the same cycle as a clear wins.
- R9: A `stop_go` pulse while a sequence is running has no effect. In particular, a pulse after SCL release does not make the block pull SCL low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brg_reload | input | 8 | Baud counter reload value; period = value+1 clocks |
| stop_go | input | 1 | Software strobe that sets the stop enable |
| buf_we | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| coll_clr | input | 1 | Write-one strobe clearing `wr_coll` |
| irq_clr | input | 1 | Write-one strobe clearing `irq_flag` |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_pd | output | 1 | 1 = pull SCL low |
| sda_pd | output | 1 | 1 = pull SDA low |
| stop_busy | output | 1 | Stop enable; clears itself on completion |
| start_seen | output | 1 | START detected status |
| stop_seen | output | 1 | STOP detected status |
| wr_coll | output | 1 | Sticky write-collision flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| tx_buf | output | 8 | Transmit buffer contents |

## Verification
The assertions assume the following about the inputs:
- `scl_in` and `sda_in` are wired-AND levels: a line reads low whenever this block pulls it down.
- No other agent moves SDA while SCL is high during the block's own sequence.
- Software strobes are single-cycle pulses.

The bench builds each line as the AND of the block's pull-down and a bench-side pull-down. It uses the bench-side pull-downs only in two cases: to stretch SCL after release, and to create foreign START/STOP events while the block is idle. Strobes are driven one clock wide on the falling edge.

// File: rtl/i2c_stop_pkg.sv
// Package: shared types for the stop sequencer.
// Assumes: nothing; pure type definitions.
package i2c_stop_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,      // nothing driven
        PH_HOLD_SCL,  // pulling SCL low, waiting to see it low
        PH_SDA_LOW,   // pulling SDA low, waiting to see it low
        PH_LOW_WAIT,  // one counter period with both lines low
        PH_SCL_HIGH,  // SCL released, counting while it reads high
        PH_SDA_RISE   // SDA released, waiting for both lines high
    } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-bit two-stage synchroniser for bus line levels.
// Assumes: idle lines are high, so the stages reset to 1.
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // shift the raw level through the stage chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_brg_count.sv
// Module: baud-rate counter with reload, run-enable and zero flag.
// Assumes: load has priority over run; the count holds while run is low.
module i2c_brg_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] reload,
    input  logic          load,
    input  logic          run,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // reload on request, otherwise count down toward zero while enabled
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= reload;
        else if (run && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_bus_mon.sv
// Module: START/STOP event monitor on synchronised line levels.
// Assumes: inputs are already synchronised to clk; lines idle high.
module i2c_bus_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_seen,
    output logic stop_seen,
    output logic stop_evt
);
    logic sda_prev;
    logic start_evt;

    // remember the previous SDA sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_s;
    end

    assign stop_evt  = scl_s &  sda_s & ~sda_prev;
    assign start_evt = scl_s & ~sda_s &  sda_prev;

    // each event sets its own status bit and clears the other one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else if (stop_evt) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b1;
        end else if (start_evt) begin
            start_seen <= 1'b1;
            stop_seen  <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_stop_seq.sv
// Module: I2C master STOP condition sequencer (top).
// Every phase waits for the synchronised line level before it advances.
// Assumes: scl_in/sda_in are wired-AND bus levels; strobes are one clock wide.
module i2c_stop_seq
    import i2c_stop_pkg::*;
#(
    parameter int BRG_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BRG_W-1:0]  brg_reload,
    input  logic              stop_go,
    input  logic              buf_we,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              coll_clr,
    input  logic              irq_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pd,
    output logic              sda_pd,
    output logic              stop_busy,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              wr_coll,
    output logic              irq_flag,
    output logic [DATA_W-1:0] tx_buf
);
    localparam int SYNC_STAGES = 2;

    phase_t     phase, phase_nx;
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       brg_load, brg_run, brg_zero;
    logic       seq_done, stop_evt;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_brg_count #(.CW(BRG_W)) u_brg (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (brg_reload),
        .load   (brg_load),
        .run    (brg_run),
        .zero   (brg_zero)
    );

    i2c_bus_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .stop_evt   (stop_evt)
    );

    // next phase, counter control and completion detection
    always_comb begin
        phase_nx = phase;
        brg_load = 1'b0;
        brg_run  = 1'b0;
        seq_done = 1'b0;
        unique case (phase)
            PH_IDLE:     if (stop_go) phase_nx = PH_HOLD_SCL;
            PH_HOLD_SCL: if (!scl_s) phase_nx = PH_SDA_LOW;
            PH_SDA_LOW: if (!sda_s) begin
                phase_nx = PH_LOW_WAIT;
                brg_load = 1'b1;
            end
            PH_LOW_WAIT: begin
                brg_run = 1'b1;
                if (brg_zero) begin
                    phase_nx = PH_SCL_HIGH;
                    brg_load = 1'b1;
                end
            end
            PH_SCL_HIGH: begin
                brg_run = scl_s;
                if (brg_zero && scl_s) phase_nx = PH_SDA_RISE;
            end
            PH_SDA_RISE: if (sda_s && scl_s) begin
                phase_nx = PH_IDLE;
                seq_done = 1'b1;
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // registered open-drain pull-down enables per phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pd <= 1'b0;
            sda_pd <= 1'b0;
        end else begin
            scl_pd <= (phase_nx == PH_HOLD_SCL) || (phase_nx == PH_SDA_LOW) ||
                      (phase_nx == PH_LOW_WAIT);
            sda_pd <= (phase_nx == PH_SDA_LOW) || (phase_nx == PH_LOW_WAIT) ||
                      (phase_nx == PH_SCL_HIGH);
        end
    end

    // stop-enable bit: set by software when idle, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n)                          stop_busy <= 1'b0;
        else if (seq_done)                   stop_busy <= 1'b0;
        else if (stop_go && phase == PH_IDLE) stop_busy <= 1'b1;
    end

    // sticky interrupt flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (seq_done) irq_flag <= 1'b1;
        else if (irq_clr)  irq_flag <= 1'b0;
    end

    // transmit buffer with collision rejection during a sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            wr_coll <= 1'b0;
        end else begin
            if (buf_we && stop_busy)       wr_coll <= 1'b1;
            else if (coll_clr)             wr_coll <= 1'b0;
            if (buf_we && !stop_busy)      tx_buf  <= buf_wdata;
        end
    end

    // stop_evt is consumed by the monitor's status bits only
    logic unused_ok;
    assign unused_ok = stop_evt;
endmodule

// File: rtl/i2c_stop_seq_chk.sv
// Module: assertion checker for i2c_stop_seq, bound to the top.
// Assumes: wired-AND line inputs and one-clock software strobes.
module i2c_stop_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_pd,
    input logic              sda_pd,
    input logic              stop_busy,
    input logic              start_seen,
    input logic              stop_seen,
    input logic              wr_coll,
    input logic              irq_flag,
    input logic              buf_we,
    input logic [DATA_W-1:0] tx_buf
);
    // R6: the two status bits are never set together
    p_status_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen));

    // R1/R5: nothing is pulled low while no sequence is enabled
    p_idle_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_busy |-> (!scl_pd && !sda_pd));

    // R3: SDA is still held low at the moment SCL is released
    p_scl_rel_sda_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_pd) |-> sda_pd);

    // R2: SDA is pulled low only while SCL is also pulled low
    p_sda_after_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pd) |-> scl_pd);

    // R4: SDA is released only after SCL has been released
    p_sda_rel_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pd) |-> !scl_pd);

    // R5: self-clearing enable comes with the interrupt and STOP status
    p_done_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_busy) |-> (irq_flag && stop_seen));

    // R7: a write during a sequence flags collision and leaves the buffer
    p_wcol_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && stop_busy) |=> (wr_coll && $stable(tx_buf)));
endmodule

bind i2c_stop_seq i2c_stop_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_pd     (scl_pd),
    .sda_pd     (sda_pd),
    .stop_busy  (stop_busy),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .wr_coll    (wr_coll),
    .irq_flag   (irq_flag),
    .buf_we     (buf_we),
    .tx_buf     (tx_buf)
);

// File: tb/i2c_stop_seq_tb.sv
// Bench: directed scenarios for the stop sequencer, one task each.
module i2c_stop_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] brg_reload = 8'd4;
    logic       stop_go = 1'b0, buf_we = 1'b0, coll_clr = 1'b0, irq_clr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       scl_pd, sda_pd, stop_busy, start_seen, stop_seen, wr_coll, irq_flag;
    logic [7:0] tx_buf;
    int         errors = 0, checks = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    assign scl_line = ~(scl_pd | ext_scl_low);
    assign sda_line = ~(sda_pd | ext_sda_low);

    i2c_stop_seq u_dut (
        .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload), .stop_go(stop_go),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .coll_clr(coll_clr),
        .irq_clr(irq_clr), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pd(scl_pd), .sda_pd(sda_pd), .stop_busy(stop_busy),
        .start_seen(start_seen), .stop_seen(stop_seen), .wr_coll(wr_coll),
        .irq_flag(irq_flag), .tx_buf(tx_buf)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input string what, input int act,
                             input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_go();
        stop_go = 1'b1; tick(1); stop_go = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && stop_busy; i++) tick(1);
    endtask

    // R1: values right after reset
    task automatic t_reset();
        check("R1", "scl_pd", scl_pd, 0);
        check("R1", "sda_pd", sda_pd, 0);
        check("R1", "stop_busy", stop_busy, 0);
        check("R1", "status", {start_seen, stop_seen}, 0);
        check("R1", "flags", {wr_coll, irq_flag}, 0);
        check("R1", "tx_buf", tx_buf, 0);
    endtask

    // R2..R5: full sequence with a given reload and optional SCL stretch
    task automatic t_sequence(input int rl, input int stretch);
        int low_t, high_t;
        brg_reload = rl[7:0];
        pulse_go();
        check("R2", "stop_busy set", stop_busy, 1);
        for (int i = 0; i < 100 && !sda_pd; i++) tick(1);
        check("R2", "SCL line low when SDA pulled", scl_line, 0);
        low_t = 0;
        while (scl_pd && low_t < 1000) begin low_t++; tick(1); end
        check_rng("R3", "SDA-low to SCL release", low_t, rl + 1, rl + 5);
        check("R3", "SDA held at SCL release", sda_pd, 1);
        if (stretch > 0) begin
            ext_scl_low = 1'b1; tick(stretch); ext_scl_low = 1'b0;
        end
        high_t = 0;
        for (int i = 0; i < 1000 && !scl_line; i++) tick(1);
        while (sda_pd && high_t < 1000) begin
            if (scl_line) high_t++;
            tick(1);
        end
        check_rng("R4", "SCL high before SDA release", high_t, rl + 1, rl + 4);
        wait_idle();
        check("R5", "stop_busy cleared", stop_busy, 0);
        check("R5", "irq_flag set", irq_flag, 1);
        check("R5", "lines released", {scl_line, sda_line}, 3);
        check("R6", "stop_seen after own STOP", {start_seen, stop_seen}, 1);
    endtask

    // R8: irq stays set until cleared
    task automatic t_irq_sticky();
        tick(5);
        check("R8", "irq sticky", irq_flag, 1);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
        check("R8", "irq cleared", irq_flag, 0);
    endtask

    // R7/R8: buffer writes outside and inside a sequence
    task automatic t_collision();
        buf_wdata = 8'hA5; buf_we = 1'b1; tick(1); buf_we = 1'b0;
        check("R7", "idle write loads buffer", tx_buf, 8'hA5);
        check("R7", "idle write no collision", wr_coll, 0);
        brg_reload = 8'd20;
        pulse_go();
        tick(8);
        buf_wdata = 8'h3C; buf_we = 1'b1; tick(1); buf_we = 1'b0;
        check("R7", "busy write sets collision", wr_coll, 1);
        check("R7", "busy write keeps buffer", tx_buf, 8'hA5);
        wait_idle();
        check("R8", "collision sticky", wr_coll, 1);
        coll_clr = 1'b1; tick(1); coll_clr = 1'b0;
        check("R8", "collision cleared", wr_coll, 0);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    endtask

    // R9: a second request after SCL release does not pull SCL again
    task automatic t_go_ignored();
        int bad;
        brg_reload = 8'd12;
        pulse_go();
        for (int i = 0; i < 200 && scl_pd; i++) tick(1);
        pulse_go();
        bad = 0;
        while (stop_busy && bad < 2000) begin
            if (scl_pd) bad = 5000;
            else bad++;
            tick(1);
        end
        check("R9", "no SCL re-pull after second request", (bad >= 5000) ? 1 : 0, 0);
        tick(3);
        check("R9", "returns idle", {stop_busy, scl_pd, sda_pd}, 0);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
    endtask

    // R6: foreign START and STOP events update status but not the interrupt
    task automatic t_monitor();
        ext_sda_low = 1'b1; tick(4);
        check("R6", "foreign START", {start_seen, stop_seen}, 2);
        ext_sda_low = 1'b0; tick(4);
        check("R6", "foreign STOP", {start_seen, stop_seen}, 1);
        check("R6", "no irq for foreign STOP", irq_flag, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_monitor();
        t_sequence(4, 0);
        t_irq_sticky();
        t_sequence(0, 0);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
        t_sequence(10, 15);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
        t_collision();
        t_go_ignored();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule